// File: doc/BRIEF.md
# Clock Divider Stage With Run-Time Step-Down

This block derives two slower clocks from a root clock: one at half the root frequency and one at a quarter. When the system has moved onto an external clock source, the dividers must step down by a factor of two. The quarter-rate output then runs at half rate, and the half-rate output passes the root clock through undivided. This keeps the divided clocks near their nominal frequencies while the root clock runs at half speed.

Step-down is requested through 4-bit encoded control words, in which only the pattern 4'b1010 means "on". Two sources can request it. The life-cycle bypass request always enables step-down once the clock switch is acknowledged. The software bypass request enables it only when the debug/test enable word is also on and the software step-down word holds 4'b1010. Every control word passes through a two-flop synchroniser before it is decoded. Each divider adopts a new ratio only at the root edge where its own output rises, so no phase is ever cut short. Releasing the request restores the original ratios under the same rule.

Top module: `clkdiv_step`

## Requirements
- R1: With step-down inactive, `clk_div2_o` has a period of 2 root cycles. `clk_div4_o` has a period of 4 root cycles, high for 2 and low for 2.
- R2: With step-down active, `clk_div4_o` has a period of 2 root cycles.
- R3: With step-down active, `clk_div2_o` follows the root clock, with a period of 1 root cycle.
- R4: Step-down is active only when `byp_ack_i` equals 4'b1010 and at least one bypass path qualifies. A near-miss value such as 4'b1011 on any control word counts as off.
- R5: `lc_byp_req_i` = 4'b1010 together with the acknowledge enables step-down, whatever the software step-down word holds.
- R6: A software bypass (`sw_byp_req_i` = 4'b1010) enables step-down only when `sw_step_i` = 4'b1010. Any other `sw_step_i` value leaves the normal ratios in place.
- R7: The software bypass request is ignored unless `dbg_en_i` = 4'b1010.
- R8: The inactive value 4'b0101 on all control words selects the normal ratios.
- R9: Every control word is registered through two root-clock flops before it is decoded. A stable request takes effect within 8 root cycles.
- R10: A ratio change happens only at a root edge where the divided output rises. No high or low phase is shorter than half a root period.
- R11: When the request returns to inactive, the divide-by-2 and divide-by-4 ratios are restored.
- R12: An asynchronous active-low reset drives both outputs low at once and returns the dividers to the non-stepped state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Root clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lc_byp_req_i | input | 4 | Life-cycle bypass request, 4'b1010 = on |
| sw_byp_req_i | input | 4 | Software bypass request, 4'b1010 = on |
| sw_step_i | input | 4 | Software step-down choice, 4'b1010 = on |
| dbg_en_i | input | 4 | Debug/test enable qualifying the software path, 4'b1010 = on |
| byp_ack_i | input | 4 | Clock switch complete, 4'b1010 = on |
| clk_div2_o | output | 1 | Half-rate clock, root pass-through when stepped |
| clk_div4_o | output | 1 | Quarter-rate clock, half-rate when stepped |

## Verification
The bench measures the output periods under the life-cycle path with and without acknowledge. It does the same under the software path with the step-down word on and off, with the debug enable withdrawn, and with a one-bit near miss of the on-pattern. Together these separate the path-qualification rules from the acknowledge gating. Releasing the request after a stepped run shows that the original ratios come back. A phase monitor measures every edge-to-edge interval on both outputs, so a switch placed off the rising boundary shows up as a short phase. An asynchronous reset asserted mid-phase shows whether the outputs drop to low without waiting for a clock edge.

// File: rtl/clkdiv_step_pkg.sv
`timescale 1ns/1ps
package clkdiv_step_pkg;
  localparam int unsigned MW = 4;
  typedef logic [MW-1:0] mubi_t;
  localparam mubi_t MUBI_ON  = 4'b1010;
  localparam mubi_t MUBI_OFF = 4'b0101;

  function automatic logic mubi_on(mubi_t v);
    return v == MUBI_ON;
  endfunction
endpackage

// File: rtl/clkdiv_step_sync.sv
`timescale 1ns/1ps
module clkdiv_step_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[0] <= RST_VAL;
        else         stg_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/clkdiv_step_req.sv
`timescale 1ns/1ps
module clkdiv_step_req
  import clkdiv_step_pkg::*;
(
  input  mubi_t lc_byp_i,
  input  mubi_t sw_byp_i,
  input  mubi_t sw_step_i,
  input  mubi_t dbg_en_i,
  input  mubi_t ack_i,
  output logic  step_o
);
  logic sw_valid;
  logic lc_valid;

  // software path qualified by debug enable
  assign sw_valid = mubi_on(sw_byp_i) & mubi_on(dbg_en_i) & mubi_on(sw_step_i);
  assign lc_valid = mubi_on(lc_byp_i);
  assign step_o   = mubi_on(ack_i) & (lc_valid | sw_valid);
endmodule

// File: rtl/clkdiv_step_div.sv
`timescale 1ns/1ps
module clkdiv_step_div #(
  parameter int unsigned LOG2_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic clk_o
);
  localparam int unsigned CW     = LOG2_DIV;
  localparam bit          BYPASS = (LOG2_DIV == 1);
  localparam logic [CW-1:0] LAST_N = CW'((1 << LOG2_DIV) - 1);
  localparam logic [CW-1:0] LAST_S = CW'((1 << (LOG2_DIV - 1)) - 1);
  localparam logic [CW-1:0] HALF_N = CW'(1 << (LOG2_DIV - 1));
  localparam logic [CW-1:0] HALF_S = BYPASS ? CW'(1) : CW'(1 << (LOG2_DIV - 2));

  logic [CW-1:0] cnt_q, cnt_inc, last, half;
  logic          sel_q, q_q, at_rise;

  always_comb begin
    last    = sel_q ? LAST_S : LAST_N;
    half    = sel_q ? HALF_S : HALF_N;
    cnt_inc = cnt_q + 1'b1;
    at_rise = (cnt_q == last);
  end

  // ratio select is sampled only where the output is about to rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= LAST_N;
      sel_q <= 1'b0;
      q_q   <= 1'b0;
    end else if (at_rise) begin
      cnt_q <= '0;
      sel_q <= step_i;
      q_q   <= 1'b1;
    end else begin
      cnt_q <= cnt_inc;
      q_q   <= (cnt_inc < half);
    end
  end

  if (BYPASS) begin : g_bypass
    assign clk_o = sel_q ? clk_i : q_q;
  end else begin : g_div
    assign clk_o = q_q;
  end

  assert_ratio_change_on_rise_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q != $past(sel_q)) |-> (q_q && cnt_q == '0));

  if (LOG2_DIV == 2) begin : g_chk4
    assert_high_width_normal_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_q && $past(q_q)) |=> !q_q);
    assert_high_width_stepped_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_q && $past(sel_q) && q_q) |=> !q_q);
  end
endmodule

// File: rtl/clkdiv_step.sv
`timescale 1ns/1ps
module clkdiv_step
  import clkdiv_step_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] lc_byp_req_i,
  input  logic [3:0] sw_byp_req_i,
  input  logic [3:0] sw_step_i,
  input  logic [3:0] dbg_en_i,
  input  logic [3:0] byp_ack_i,
  output logic       clk_div2_o,
  output logic       clk_div4_o
);
  localparam int unsigned NIN = 5;
  localparam int unsigned SW  = NIN * MW;

  logic [SW-1:0] raw, syn;
  logic          step_act;

  assign raw = {lc_byp_req_i, sw_byp_req_i, sw_step_i, dbg_en_i, byp_ack_i};

  clkdiv_step_sync #(
    .W(SW), .STAGES(SYNC_STAGES), .RST_VAL({NIN{MUBI_OFF}})
  ) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(syn)
  );

  clkdiv_step_req u_req (
    .lc_byp_i (syn[4*MW +: MW]),
    .sw_byp_i (syn[3*MW +: MW]),
    .sw_step_i(syn[2*MW +: MW]),
    .dbg_en_i (syn[1*MW +: MW]),
    .ack_i    (syn[0 +: MW]),
    .step_o   (step_act)
  );

  clkdiv_step_div #(.LOG2_DIV(1)) u_div2 (
    .clk_i, .rst_ni, .step_i(step_act), .clk_o(clk_div2_o)
  );

  clkdiv_step_div #(.LOG2_DIV(2)) u_div4 (
    .clk_i, .rst_ni, .step_i(step_act), .clk_o(clk_div4_o)
  );

  assert_step_needs_ack_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_act |-> ($past(byp_ack_i, 2) == MUBI_ON));

  assert_sw_needs_dbg_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_act && $past(lc_byp_req_i, 2) != MUBI_ON) |-> ($past(dbg_en_i, 2) == MUBI_ON));
endmodule

// File: tb/clkdiv_step_bench.sv
`timescale 1ns/1ps
module clkdiv_step_bench;
  localparam realtime TCK = 20.0;
  localparam logic [3:0] ON = 4'b1010, OFF = 4'b0101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] lc = OFF, swb = OFF, sws = OFF, dbg = OFF, ack = OFF;
  logic c2, c4;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  int glitch2 = 0, glitch4 = 0;
  realtime e2 = 0, e4 = 0, r2 = 0, r4 = 0, f4 = 0;
  int per2 = 0, per4 = 0, hi4 = 0;

  always #(TCK/2) clk = ~clk;

  clkdiv_step u_clkdiv_step (
    .clk_i(clk), .rst_ni(rst_n), .lc_byp_req_i(lc), .sw_byp_req_i(swb),
    .sw_step_i(sws), .dbg_en_i(dbg), .byp_ack_i(ack),
    .clk_div2_o(c2), .clk_div4_o(c4)
  );

  // phase and period monitors
  always @(c2) begin
    if (mon_on && ($realtime - e2) < TCK/2 - 0.1) glitch2++;
    e2 = $realtime;
    if (c2) begin
      if (r2 > 0) per2 = int'($realtime - r2);
      r2 = $realtime;
    end
  end
  always @(c4) begin
    if (mon_on && ($realtime - e4) < TCK/2 - 0.1) glitch4++;
    e4 = $realtime;
    if (c4) begin
      if (r4 > 0) per4 = int'($realtime - r4);
      r4 = $realtime;
    end else if (r4 > 0) begin
      hi4 = int'($realtime - r4);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (16) @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic [3:0] l, s, st, d, a);
    @(negedge clk);
    lc = l; swb = s; sws = st; dbg = d; ack = a;
  endtask

  task automatic expect_ratio(input bit stepped, input string req);
    settle();
    check(per2 == (stepped ? 20 : 40), {req, " div2 period"}, per2, stepped ? 20 : 40);
    check(per4 == (stepped ? 40 : 80), {req, " div4 period"}, per4, stepped ? 40 : 80);
  endtask

  task automatic t_reset();
    #3;
    check(c2 == 1'b0, "R12 div2 low in reset", c2, 0);
    check(c4 == 1'b0, "R12 div4 low in reset", c4, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
  endtask

  task automatic t_normal();
    expect_ratio(1'b0, "R1 R8 default");
    check(hi4 == 40, "R1 div4 high time", hi4, 40);
  endtask

  task automatic t_lc_step();
    drive(ON, OFF, OFF, OFF, ON);
    expect_ratio(1'b1, "R5 R9 lc step");
    check(per2 == 20, "R3 div2 pass-through", per2, 20);
    check(per4 == 40, "R2 div4 halved", per4, 40);
    drive(OFF, OFF, OFF, OFF, ON);
    expect_ratio(1'b0, "R11 lc release");
    check(hi4 == 40, "R11 div4 high restored", hi4, 40);
  endtask

  task automatic t_no_ack();
    drive(ON, ON, ON, ON, OFF);
    expect_ratio(1'b0, "R4 no ack");
    drive(ON, OFF, OFF, OFF, 4'b1011);
    expect_ratio(1'b0, "R4 ack near miss");
    drive(4'b1000, OFF, OFF, OFF, ON);
    expect_ratio(1'b0, "R4 lc near miss");
  endtask

  task automatic t_sw();
    drive(OFF, ON, ON, ON, ON);
    expect_ratio(1'b1, "R6 sw step on");
    drive(OFF, ON, OFF, ON, ON);
    expect_ratio(1'b0, "R6 sw step off");
    drive(OFF, ON, ON, OFF, ON);
    expect_ratio(1'b0, "R7 dbg off");
    drive(OFF, ON, ON, 4'b1110, ON);
    expect_ratio(1'b0, "R7 dbg near miss");
    drive(ON, ON, OFF, OFF, ON);
    expect_ratio(1'b1, "R5 lc overrides sw step off");
    drive(OFF, OFF, OFF, OFF, OFF);
    expect_ratio(1'b0, "R8 all off");
  endtask

  task automatic t_glitch();
    check(glitch2 == 0, "R10 div2 short phases", glitch2, 0);
    check(glitch4 == 0, "R10 div4 short phases", glitch4, 0);
  endtask

  task automatic t_async_reset();
    drive(ON, OFF, OFF, OFF, ON);
    settle();
    @(posedge clk);
    #3;
    mon_on = 1'b0;
    rst_n = 1'b0;
    #1;
    check(c2 == 1'b0, "R12 div2 async low", c2, 0);
    check(c4 == 1'b0, "R12 div4 async low", c4, 0);
    drive(OFF, OFF, OFF, OFF, OFF);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    mon_on = 1'b1;
    expect_ratio(1'b0, "R12 non-stepped after reset");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_normal();
    t_lc_step();
    t_no_ack();
    t_sw();
    t_glitch();
    t_async_reset();
    t_glitch();
    finish_run();
  end

  initial begin
    #(TCK * 200000);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end
endmodule